// File: doc/BRIEF.md
# Processor exception entry controller

This block is the exception entry logic for the system-control coprocessor of a 32-bit core. Two kinds of request can arrive. A translation-miss request is raised when a load, store or fetch address found no mapping. A general request is raised for any other exception. On the clock edge that accepts a request, the block does the following in one step:

- records why the exception happened;
- captures the faulting address and rewrites the page-table pointer and the translation tag from it;
- saves the restart address unless a handler is already running;
- raises the exception-level flag.

In the cycle after the request, the block gives the fetch unit a redirect pulse and a handler address.

The handler address depends on three things. If the exception-level flag was already set, or the request is a general one, the common handler is used. For a translation miss taken with the flag clear, the fast refill handler is used only when the faulting address lies outside the fixed unmapped kernel window and an external lookup reports that no translation entry covers the address. A small register port lets software read and write the six state registers. The translation table itself, interrupt arbitration and the return-from-exception path are not part of this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On a translation miss, the cause register is rewritten as a whole. Bits 6:2 hold 3 for a store miss (`tlbStoreMiss`=1) and 2 for a load or fetch miss. Bit 31 holds the delay-slot flag. Every other bit is 0.
- R2: On a translation miss, the bad-address register is loaded with `faultVaddr`.
- R3: On a translation miss, the context register keeps its bits under mask 0xFF80000F. The rest is replaced with (`faultVaddr` >> 9) & 0x007FFFF0.
- R4: On a translation miss, the entry-tag register is loaded with `faultVaddr` & 0xFFFFE000.
- R5: If status bit 1 (EXL) is already 1 when a request is taken, the handler address is 0x80000180 and the EPC register keeps its value.
- R6: For a translation miss taken with EXL clear, the handler address is 0x80000000 exactly when `faultVaddr` is outside 0x80000000..0xBFFFFFFF and `tlbRangeHit` is 0. Otherwise it is 0x80000180.
- R7: After any accepted request, status bit 1 reads 1 and all other status bits are unchanged.
- R8: A general request always uses handler 0x80000180. It changes only bit 31 of the cause register and leaves the bad-address, context and entry-tag registers unchanged.
- R9: On every accepted request, cause bit 31 is set to `inDelaySlot`. When EPC is written (EXL was clear), it receives `faultPc` minus 4 if `inDelaySlot` is 1, and `faultPc` otherwise.
- R10: `redirectValid` is high for exactly the one cycle after each cycle with an accepted request, with `redirectAddr` holding the handler address in that cycle. It is low at all other times.
- R11: If both requests are raised in the same cycle, the translation miss is taken and the general request is ignored.
- R12: Reset makes cause, bad-address, context, entry-tag and EPC read 0, makes status read 0x00000002, and makes `redirectValid` 0.
- R13: Register select codes are 0 cause, 1 bad-address, 2 context, 3 entry-tag, 4 EPC and 5 status. A write with `regWrEn` takes effect at the next edge, and reads are combinational. Select codes 6 and 7 read 0 and writes to them change nothing. A write in a cycle that accepts a request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tlbMissReq | input | 1 | Translation-miss exception request |
| tlbStoreMiss | input | 1 | 1 when the miss came from a store |
| genReq | input | 1 | General exception request |
| faultPc | input | 32 | Address of the faulting instruction |
| faultVaddr | input | 32 | Faulting virtual address |
| inDelaySlot | input | 1 | Faulting instruction is in a branch delay slot |
| tlbRangeHit | input | 1 | External lookup found an entry covering `faultVaddr` |
| regWrEn | input | 1 | Software register write strobe |
| regWrSel | input | 3 | Register select for writes |
| regWrData | input | 32 | Write data |
| regRdSel | input | 3 | Register select for reads |
| regRdData | output | 32 | Read data |
| redirectValid | output | 1 | One-cycle fetch redirect pulse |
| redirectAddr | output | 32 | Handler address |

## Verification
Every register update appears on the read port one cycle after the accepting edge. The handler choice is visible on `redirectAddr` in the same cycle as the pulse. This means a wrong EXL value, a wrong window comparison or a wrong mask shows up within one clock of the request that uses it. A stale EXL bit shows up on the very next request, as a wrong handler address or an EPC that was overwritten when it should have been kept. The sweep covers both EXL states, both miss types, both delay-slot values, both lookup results and every edge of the kernel window. This way each path to the handler address and each masked field is exercised against a model computed in the bench.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    SEL_CAUSE   = 3'd0,
    SEL_BADADDR = 3'd1,
    SEL_CONTEXT = 3'd2,
    SEL_TAG     = 3'd3,
    SEL_EPC     = 3'd4,
    SEL_STATUS  = 3'd5
  } regSel_e;

  // Strobes from control to datapath for one accepted exception.
  typedef struct packed {
    logic takeTlb;
    logic takeGen;
    logic storeMiss;
    logic inDelay;
    logic writeEpc;
  } excStrobe_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] GEN_VEC    = 32'h8000_0180,
  parameter logic [31:0] REFILL_VEC = 32'h8000_0000,
  parameter logic [31:0] WIN_LO     = 32'h8000_0000,
  parameter logic [31:0] WIN_HI     = 32'hBFFF_FFFF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tlbMissReq,
  input  logic            tlbStoreMiss,
  input  logic            genReq,
  input  logic            inDelaySlot,
  input  logic            tlbRangeHit,
  input  logic [XLEN-1:0] faultVaddr,
  input  logic            exlNow,
  output excStrobe_t      strb,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectAddr
);

  logic            inWindow;
  logic            useRefill;
  logic [XLEN-1:0] targetAddr;

  assign inWindow  = (faultVaddr >= WIN_LO) && (faultVaddr <= WIN_HI);
  assign useRefill = tlbMissReq && !exlNow && !inWindow && !tlbRangeHit;

  always_comb begin
    strb           = '0;
    strb.takeTlb   = tlbMissReq;
    strb.takeGen   = genReq && !tlbMissReq;
    strb.storeMiss = tlbStoreMiss;
    strb.inDelay   = inDelaySlot;
    strb.writeEpc  = !exlNow;
    targetAddr     = useRefill ? REFILL_VEC : GEN_VEC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectAddr  <= '0;
    end else begin
      redirectValid <= strb.takeTlb || strb.takeGen;
      if (strb.takeTlb || strb.takeGen) redirectAddr <= targetAddr;
    end
  end

  AST_GEN_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeGen |=> (redirectValid && redirectAddr == GEN_VEC)); // R8
  AST_EXL_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeTlb && exlNow) |=> (redirectAddr == GEN_VEC)); // R5
  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(tlbMissReq || genReq)); // R10

endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  excStrobe_t      strb,
  input  logic [XLEN-1:0] faultPc,
  input  logic [XLEN-1:0] faultVaddr,
  input  logic            regWrEn,
  input  logic [2:0]      regWrSel,
  input  logic [XLEN-1:0] regWrData,
  input  logic [2:0]      regRdSel,
  output logic [XLEN-1:0] regRdData,
  output logic            exlNow
);

  localparam int          CODE_W    = 5;
  localparam int          CODE_LSB  = 2;
  localparam int          BD_BIT    = XLEN - 1;
  localparam int          EXL_BIT   = 1;
  localparam int          CTX_SHIFT = 9;
  localparam logic [31:0] CTX_KEEP  = 32'hFF80_000F;
  localparam logic [31:0] CTX_FIELD = 32'h007F_FFF0;
  localparam logic [31:0] TAG_MASK  = 32'hFFFF_E000;
  localparam logic [CODE_W-1:0] CODE_LOAD  = 5'd2;
  localparam logic [CODE_W-1:0] CODE_STORE = 5'd3;
  localparam logic [XLEN-1:0] STATUS_RST = XLEN'(1) << EXL_BIT;

  logic [XLEN-1:0] causeQ, badVaddrQ, contextQ, tagQ, epcQ, statusQ;
  logic            anyTake;
  logic            swWr;
  logic [XLEN-1:0] missCause;
  logic [XLEN-1:0] epcNext;

  assign anyTake = strb.takeTlb || strb.takeGen;
  assign swWr    = regWrEn && !anyTake;
  assign exlNow  = statusQ[EXL_BIT];
  assign epcNext = strb.inDelay ? (faultPc - XLEN'(4)) : faultPc;

  always_comb begin
    missCause = '0;
    missCause[CODE_LSB +: CODE_W] = strb.storeMiss ? CODE_STORE : CODE_LOAD;
    missCause[BD_BIT] = strb.inDelay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) causeQ <= '0;
    else if (strb.takeTlb) causeQ <= missCause;
    else if (strb.takeGen) causeQ[BD_BIT] <= strb.inDelay;
    else if (swWr && regWrSel == SEL_CAUSE) causeQ <= regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badVaddrQ <= '0;
      contextQ  <= '0;
      tagQ      <= '0;
    end else if (strb.takeTlb) begin
      badVaddrQ <= faultVaddr;
      contextQ  <= (contextQ & CTX_KEEP) | ((faultVaddr >> CTX_SHIFT) & CTX_FIELD);
      tagQ      <= faultVaddr & TAG_MASK;
    end else if (swWr) begin
      if (regWrSel == SEL_BADADDR) badVaddrQ <= regWrData;
      if (regWrSel == SEL_CONTEXT) contextQ  <= regWrData;
      if (regWrSel == SEL_TAG)     tagQ      <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) epcQ <= '0;
    else if (anyTake) begin
      if (strb.writeEpc) epcQ <= epcNext;
    end else if (swWr && regWrSel == SEL_EPC) epcQ <= regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= STATUS_RST;
    else if (anyTake) statusQ[EXL_BIT] <= 1'b1;
    else if (swWr && regWrSel == SEL_STATUS) statusQ <= regWrData;
  end

  always_comb begin
    case (regRdSel)
      SEL_CAUSE:   regRdData = causeQ;
      SEL_BADADDR: regRdData = badVaddrQ;
      SEL_CONTEXT: regRdData = contextQ;
      SEL_TAG:     regRdData = tagQ;
      SEL_EPC:     regRdData = epcQ;
      SEL_STATUS:  regRdData = statusQ;
      default:     regRdData = '0;
    endcase
  end

  AST_EPC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (anyTake && !strb.writeEpc) |=> $stable(epcQ)); // R5
  AST_EXL_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    anyTake |=> exlNow); // R7
  AST_BADADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeTlb |=> (badVaddrQ == $past(faultVaddr))); // R2

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tlbMissReq,
  input  logic            tlbStoreMiss,
  input  logic            genReq,
  input  logic [XLEN-1:0] faultPc,
  input  logic [XLEN-1:0] faultVaddr,
  input  logic            inDelaySlot,
  input  logic            tlbRangeHit,
  input  logic            regWrEn,
  input  logic [2:0]      regWrSel,
  input  logic [XLEN-1:0] regWrData,
  input  logic [2:0]      regRdSel,
  output logic [XLEN-1:0] regRdData,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectAddr
);

  excStrobe_t strb;
  logic       exlNow;

  exc_ctrl #(.XLEN(XLEN)) uCtrl (
    .clk(clk), .rstN(rstN),
    .tlbMissReq(tlbMissReq), .tlbStoreMiss(tlbStoreMiss), .genReq(genReq),
    .inDelaySlot(inDelaySlot), .tlbRangeHit(tlbRangeHit),
    .faultVaddr(faultVaddr), .exlNow(exlNow), .strb(strb),
    .redirectValid(redirectValid), .redirectAddr(redirectAddr)
  );

  exc_regs #(.XLEN(XLEN)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .faultPc(faultPc), .faultVaddr(faultVaddr),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData), .exlNow(exlNow)
  );

endmodule

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tlbMissReq = 0, tlbStoreMiss = 0, genReq = 0;
  logic [31:0] faultPc = 0, faultVaddr = 0;
  logic        inDelaySlot = 0, tlbRangeHit = 0;
  logic        regWrEn = 0;
  logic [2:0]  regWrSel = 0, regRdSel = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        redirectValid;
  logic [31:0] redirectAddr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rstN(rstN), .tlbMissReq(tlbMissReq), .tlbStoreMiss(tlbStoreMiss),
    .genReq(genReq), .faultPc(faultPc), .faultVaddr(faultVaddr),
    .inDelaySlot(inDelaySlot), .tlbRangeHit(tlbRangeHit), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .regRdSel(regRdSel),
    .regRdData(regRdData), .redirectValid(redirectValid), .redirectAddr(redirectAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic swWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    regRdSel = sel;
    #0.5;
    v = regRdData;
  endtask

  // Raise a request, check the pulse and the address, then check the pulse is gone.
  task automatic fire(input logic tlb, input logic gen, input logic [31:0] expAddr);
    @(negedge clk);
    tlbMissReq = tlb; genReq = gen;
    @(negedge clk);
    tlbMissReq = 0; genReq = 0;
    chk("R10 pulse high", {31'b0, redirectValid}, 32'd1);
    chk("R6 R8 handler address", redirectAddr, expAddr);
    @(negedge clk);
    chk("R10 pulse single", {31'b0, redirectValid}, 32'd0);
  endtask

  function automatic logic [31:0] addrOf(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hBFFF_FFFF;
      4: return 32'hC000_0000;
      5: return 32'h1234_5678;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk("R12 R13 reset value", v, (s == 5) ? 32'h2 : 32'h0);
    end
    chk("R12 no redirect", {31'b0, redirectValid}, 32'd0);

    // R13 software access and ignored select codes
    swWrite(3'd2, 32'h1357_9BDF);
    rd(3'd2, v); chk("R13 context write", v, 32'h1357_9BDF);
    swWrite(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R13 unused read", v, 32'h0);
    rd(3'd0, v); chk("R13 unused write no effect", v, 32'h0);
    rd(3'd2, v); chk("R13 unused write no effect", v, 32'h1357_9BDF);

    // Sweep translation misses
    for (int e = 0; e < 2; e++)
      for (int st = 0; st < 2; st++)
        for (int d = 0; d < 2; d++)
          for (int h = 0; h < 2; h++)
            for (int a = 0; a < 7; a++) begin
              logic [31:0] va, pc, ctx0, epc0, stat0, expAddr, expEpc;
              va = addrOf(a);
              pc = 32'h0040_1000 + 32'(a * 16 + h * 4 + d * 64);
              ctx0 = 32'hA5A5_A5A5 ^ 32'(a);
              epc0 = 32'hDEAD_0000 + 32'(a);
              stat0 = 32'h0000_00F0 | (32'(e) << 1);
              swWrite(3'd2, ctx0);
              swWrite(3'd4, epc0);
              swWrite(3'd0, 32'h0000_FF00);
              swWrite(3'd5, stat0);
              tlbStoreMiss = st[0]; inDelaySlot = d[0]; tlbRangeHit = h[0];
              faultVaddr = va; faultPc = pc;
              if (e == 0 && !(va >= 32'h8000_0000 && va <= 32'hBFFF_FFFF) && h == 0)
                expAddr = 32'h8000_0000;
              else
                expAddr = 32'h8000_0180;
              expEpc = (e != 0) ? epc0 : (d != 0 ? pc - 32'd4 : pc);
              fire(1'b1, 1'b0, expAddr);
              rd(3'd0, v); chk("R1 R9 cause", v, (32'(d) << 31) | ((st != 0 ? 32'd3 : 32'd2) << 2));
              rd(3'd1, v); chk("R2 bad address", v, va);
              rd(3'd2, v); chk("R3 context", v, (ctx0 & 32'hFF80_000F) | ((va >> 9) & 32'h007F_FFF0));
              rd(3'd3, v); chk("R4 entry tag", v, va & 32'hFFFF_E000);
              rd(3'd4, v); chk("R5 R9 epc", v, expEpc);
              rd(3'd5, v); chk("R7 status", v, stat0 | 32'h2);
            end

    // General requests, both EXL states and delay values
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++) begin
        logic [31:0] pc;
        pc = 32'h0000_2000 + 32'(e * 32 + d * 8);
        swWrite(3'd0, 32'h0000_FF00 | (32'(~d[0]) << 31));
        swWrite(3'd1, 32'h1111_1111);
        swWrite(3'd2, 32'h2222_2222);
        swWrite(3'd3, 32'h3333_3333);
        swWrite(3'd4, 32'h4444_4444);
        swWrite(3'd5, 32'(e) << 1);
        faultPc = pc; inDelaySlot = d[0]; faultVaddr = 32'h0000_0004; tlbRangeHit = 0;
        fire(1'b0, 1'b1, 32'h8000_0180);
        rd(3'd0, v); chk("R8 R9 general cause", v, 32'h0000_FF00 | (32'(d) << 31));
        rd(3'd1, v); chk("R8 bad address kept", v, 32'h1111_1111);
        rd(3'd2, v); chk("R8 context kept", v, 32'h2222_2222);
        rd(3'd3, v); chk("R8 tag kept", v, 32'h3333_3333);
        rd(3'd4, v); chk("R5 R9 general epc", v, (e != 0) ? 32'h4444_4444 : (d != 0 ? pc - 32'd4 : pc));
        rd(3'd5, v); chk("R7 general status", v, 32'h2);
      end

    // R11 both requests: miss wins
    swWrite(3'd5, 32'h0);
    swWrite(3'd0, 32'h0);
    faultVaddr = 32'h0000_8000; tlbRangeHit = 0; tlbStoreMiss = 0; inDelaySlot = 0;
    fire(1'b1, 1'b1, 32'h8000_0000);
    rd(3'd0, v); chk("R11 miss taken", v, 32'd2 << 2);
    rd(3'd1, v); chk("R11 miss taken", v, 32'h0000_8000);

    // R13 write dropped in an accepting cycle
    swWrite(3'd2, 32'h5555_5555);
    @(negedge clk);
    genReq = 1; regWrEn = 1; regWrSel = 3'd2; regWrData = 32'h9999_9999;
    @(negedge clk);
    genReq = 0; regWrEn = 0;
    rd(3'd2, v); chk("R13 write dropped", v, 32'h5555_5555);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule